// File: doc/BRIEF.md
# Multi-Mode Watchdog Interval Timer

This block is a watchdog counter with three ways of reporting overflow. Software controls it through one 8-bit control register on a simple bus that has an address, write data, a write strobe and combinational read data. The register holds a run bit and a two-bit mode field. The mode decides what an overflow does: it raises a level interrupt that can be masked (interval mode), it sends a single-cycle non-maskable interrupt pulse, or it sends a single-cycle system reset request pulse.

An 8-bit main counter advances on ticks from a free-running prescaler. The `DIV_SEL` parameter sets the tick period to P = 2^(2*DIV_SEL+1) clocks. Every wrap of the counter from 255 to 0 sets a pending flag, and software clears that flag through a dedicated clear input. The run bit and both mode bits can only be set by a write. Once set, only hardware reset clears them, so a watchdog that has been armed cannot be disarmed by errant code.

A restart clears only the main counter and leaves the prescaler running. The first period after a restart can therefore be up to one tick short. If a watchdog mode is entered while the pending flag is still set, a non-maskable interrupt is raised at once.

Top module: `wdt_multimode`

## Requirements
- R1: The control register sits at address `REG_ADDR`. Bit 7 is run, bit 4 is mode-high and bit 3 is mode-low. All other bits read as 0. Reads at any other address return 0, and writes to any other address change nothing.
- R2: After hardware reset the register reads 00h and all three event outputs are low.
- R3: Run, mode-high and mode-low are set-only. Writing 0 to a bit that is already 1 leaves it at 1, and a running counter keeps running.
- R4: The counter advances only while run is 1 and the mode {mode-high, mode-low} is not 00. It overflows every 256*P clocks, and the first overflow after start lands between 255*P+1 and 256*P clocks after the write.
- R5: Writing the register with bit 7 set restarts the count from zero without touching the prescaler. The next overflow lands between 255*P+1 and 256*P clocks after that write.
- R6: Every overflow sets the pending flag. A one-cycle pulse on `pend_clr` clears it.
- R7: In mode 10 each overflow produces a one-cycle pulse on `nmi_o`, and `irq_o` and `rst_req_o` stay low.
- R8: In mode 11 each overflow produces a one-cycle pulse on `rst_req_o`, and `nmi_o` stays low.
- R9: In mode 01, `irq_o` follows the pending flag and no other event output toggles.
- R10: In mode 00 no event output ever asserts, even with run set.
- R11: A write that moves mode-high from 0 to 1 while the pending flag is 1 pulses `nmi_o` in the cycle after the write. If the flag is clear, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data (combinational) |
| pend_clr | input | 1 | Clears the pending flag |
| irq_o | output | 1 | Maskable interval interrupt (level) |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The assertions check four things on every cycle. A set run bit never drops. A reset request is one cycle wide and appears only in mode 11. Every NMI pulse comes with mode-high set. A restart leaves the counter at zero, and without a tick or restart the counter does not move. The bench scenarios are what show the overflow periods, including the short first period after a restart. They also show the read-back masking, that writes of 0 to set bits have no effect, that mode 00 stays silent, and that the immediate NMI depends on the pending flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int RUN_BIT = 7;
    localparam int MHI_BIT = 4;
    localparam int MLO_BIT = 3;

    typedef enum logic [1:0] {
        WM_STOP     = 2'b00,
        WM_INTERVAL = 2'b01,
        WM_NMI      = 2'b10,
        WM_RESET    = 2'b11
    } wmode_e;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int DIV_LG = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    typedef struct packed {
        logic [DIV_LG-1:0] pre;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pre = st_q.pre + 1'b1;
        tick     = &st_q.pre;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        ovf  = en && tick && (&st_q.cnt) && !clr;
        if (clr)             st_d.cnt = '0;
        else if (en && tick) st_d.cnt = st_q.cnt + 1'b1;
        cnt = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a restart leaves the count at zero
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));
    // R4: without tick or restart the count holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(en && tick)) |=> $stable(st_q.cnt));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int           ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    input  logic              pend_clr,
    input  logic              ovf,
    output logic              cnt_en,
    output logic              restart,
    output logic              irq,
    output logic              nmi,
    output logic              rst_req
);
    typedef struct packed {
        logic run;
        logic mhi;
        logic mlo;
        logic pend;
        logic nmi;
        logic rst;
    } ctl_t;

    ctl_t   st_d, st_q;
    logic   hit, wr;
    wmode_e mode_q;

    always_comb begin
        hit     = (bus_addr == REG_ADDR);
        wr      = bus_we && hit;
        mode_q  = wmode_e'({st_q.mhi, st_q.mlo});
        st_d    = st_q;

        st_d.run = st_q.run | (wr & bus_wdata[RUN_BIT]);
        st_d.mhi = st_q.mhi | (wr & bus_wdata[MHI_BIT]);
        st_d.mlo = st_q.mlo | (wr & bus_wdata[MLO_BIT]);
        restart  = wr & bus_wdata[RUN_BIT];

        if (ovf)           st_d.pend = 1'b1;
        else if (pend_clr) st_d.pend = 1'b0;

        st_d.nmi = (ovf && mode_q == WM_NMI)
                 || (!st_q.mhi && st_d.mhi && st_q.pend);
        st_d.rst = ovf && mode_q == WM_RESET;

        cnt_en    = st_q.run && mode_q != WM_STOP;
        irq       = st_q.pend && mode_q == WM_INTERVAL;
        nmi       = st_q.nmi;
        rst_req   = st_q.rst;
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[RUN_BIT] = st_q.run;
            bus_rdata[MHI_BIT] = st_q.mhi;
            bus_rdata[MLO_BIT] = st_q.mlo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: run never drops once set
    a_r3_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |=> st_q.run);
    // R8: reset request is one cycle wide
    a_r8_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst |=> !st_q.rst);
    // R8: reset request only in mode 11
    a_r8_rst_mode: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst |-> (st_q.mhi && st_q.mlo));
    // R7/R11: every NMI comes with mode-high set
    a_r11_nmi_mhi: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.nmi |-> st_q.mhi);
endmodule

// File: rtl/wdt_multimode.sv
module wdt_multimode #(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 4'h9,
    parameter int                DIV_SEL  = 0,
    parameter int                CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    input  logic              pend_clr,
    output logic              irq_o,
    output logic              nmi_o,
    output logic              rst_req_o
);
    localparam int DIV_LG = 2 * DIV_SEL + 1;

    logic             tick, ovf, cnt_en, restart;
    logic [CNT_W-1:0] cnt;

    wdt_prescale #(.DIV_LG(DIV_LG)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    wdt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(cnt_en),
        .clr(restart), .cnt(cnt), .ovf(ovf)
    );

    wdt_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .pend_clr(pend_clr), .ovf(ovf), .cnt_en(cnt_en),
        .restart(restart), .irq(irq_o), .nmi(nmi_o), .rst_req(rst_req_o)
    );

    // R4: a counter that was never enabled stays at zero
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !$past(cnt_en) && cnt == '0) |=> (cnt == '0 || cnt_en));
endmodule

// File: tb/tb_wdt_multimode.sv
module tb_wdt_multimode;
    localparam int          DIV_SEL = 0;
    localparam int          P       = 1 << (2 * DIV_SEL + 1);
    localparam logic [3:0]  RA      = 4'h9;
    localparam int          LO      = 255 * P + 1;
    localparam int          HI      = 256 * P;

    logic       clk = 0, rst_n = 0, bus_we = 0, pend_clr = 0;
    logic [3:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic       irq_o, nmi_o, rst_req_o;
    int errors = 0, checks = 0, stray = 0, cyc = 0;

    always #5 clk = ~clk;

    wdt_multimode #(.ADDR_W(4), .REG_ADDR(RA), .DIV_SEL(DIV_SEL)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pend_clr(pend_clr),
        .irq_o(irq_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=[%0d..%0d]", req, act, lo, hi);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; bus_we = 0; pend_clr = 0; bus_addr = RA; bus_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0; bus_addr = RA;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_addr = RA;
    endtask

    task automatic clr_pend();
        pend_clr = 1;
        @(negedge clk);
        pend_clr = 0;
    endtask

    // sel: 0 irq, 1 nmi, 2 rst; counts negedges until output high
    task automatic wait_out(input int sel, output int k);
        k = 0;
        while (k <= HI + 8) begin
            if ((sel == 0 && irq_o) || (sel == 1 && nmi_o) || (sel == 2 && rst_req_o))
                return;
            if (sel != 0 && irq_o) stray++;
            if (sel != 1 && nmi_o) stray++;
            if (sel != 2 && rst_req_o) stray++;
            @(negedge clk);
            k++;
        end
        k = -1;
    endtask

    initial begin
        int v, k;
        do_reset();
        // R2 reset state
        rd(RA, v); chk("R2 reg after reset", v, 0);
        chk("R2 outputs after reset", {irq_o, nmi_o, rst_req_o}, 0);

        // R1 wrong address write ignored, masking
        wr(RA + 1, 8'hFF);
        rd(RA, v); chk("R1 write elsewhere ignored", v, 0);
        rd(RA + 1, v); chk("R1 other address reads 0", v, 0);
        wr(RA, 8'hFF);
        rd(RA, v); chk("R1 readback mask", v, 8'h98);

        // R4/R6/R9 interval mode
        do_reset();
        stray = 0;
        wr(RA, 8'h88);
        rd(RA, v); chk("R1 readback 88", v, 8'h88);
        wait_out(0, k); chk_rng("R4 first overflow", k, LO, HI);
        chk("R9 no nmi/rst in interval", stray, 0);
        clr_pend();
        chk("R6 pend cleared drops irq", irq_o, 0);
        wait_out(0, k); chk("R4 steady period", k + 1, HI);
        // R3 sticky bits
        wr(RA, 8'h00);
        rd(RA, v); chk("R3 zero write ignored", v, 8'h88);
        clr_pend();
        wait_out(0, k); chk_rng("R3 still counting", k, 1, HI);
        // R5 restart
        clr_pend();
        repeat (300) @(negedge clk);
        wr(RA, 8'h88);
        wait_out(0, k); chk_rng("R5 restart period", k, LO, HI);

        // R7 mode 10
        do_reset();
        stray = 0;
        wr(RA, 8'h90);
        wait_out(1, k); chk_rng("R7 nmi period", k, LO, HI);
        @(negedge clk); chk("R7 nmi one cycle", nmi_o, 0);
        chk("R7 no irq/rst", stray + irq_o + rst_req_o, 0);

        // R8 mode 11
        do_reset();
        stray = 0;
        wr(RA, 8'h98);
        wait_out(2, k); chk_rng("R8 rst period", k, LO, HI);
        @(negedge clk); chk("R8 rst one cycle", rst_req_o, 0);
        chk("R8 no nmi", stray + nmi_o, 0);

        // R10 mode 00 with run
        do_reset();
        wr(RA, 8'h80);
        v = 0;
        for (int i = 0; i < 3 * HI; i++) begin
            if (irq_o || nmi_o || rst_req_o) v++;
            @(negedge clk);
        end
        chk("R10 silent in mode 00", v, 0);
        wr(RA, 8'h08);
        wait_out(0, k); chk_rng("R4 enable by mode write", k, LO, HI);

        // R11 immediate NMI
        do_reset();
        wr(RA, 8'h10);
        chk("R11 no nmi without pending", nmi_o, 0);
        do_reset();
        wr(RA, 8'h88);
        wait_out(0, k);
        chk("R11 pending before", nmi_o, 0);
        wr(RA, 8'h90);
        chk("R11 immediate nmi", nmi_o, 1);
        @(negedge clk); chk("R11 nmi one cycle", nmi_o, 0);
        rd(RA, v); chk("R3 mode bits accumulate", v, 8'h98);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule